// File: doc/BRIEF.md
# Wired interrupt pending bank

This block keeps one pending bit for each wired interrupt source of a controller that sits next to a single hart. Each source has a three-bit source mode that comes from a configuration file held elsewhere. From the mode and the raw wire, the block forms a rectified input and watches it for rising transitions. Software writes to the pending bits are applied under a bit mask. A claim strobe, produced when the top-interrupt register is written, carries one source identity. The block combines these events according to the rules of each mode and drives the pending vector. Enable masking, priority selection and threshold comparison happen downstream.

A configuration write strobe names the source whose mode has just changed. The mode inputs already carry the new value in that cycle. For that source, edge detection is suppressed for the one cycle, so a mode change alone never creates a false rising edge. Level modes drive the pending output straight from the rectified input, so no separate pending state is kept for them.

Top module: `irq_pend_bank`

## Requirements
- R1: Mode codes are 0 inactive, 1 detached, 4 rising-edge (Edge1), 5 falling-edge (Edge0), 6 high-level (Level1) and 7 low-level (Level0). Codes 2 and 3 behave as inactive. The rectified input equals the raw wire in modes 4 and 6, equals its inverse in modes 5 and 7, and is zero in every other mode.
- R2: In an inactive mode, the pending bit reads zero from the cycle after the mode is applied. Wires, software writes and claims do not change this.
- R3: In detached mode, the raw wire has no effect. Only a software write of 1 can set the bit.
- R4: In detached and edge modes, a masked software write of 0 clears the bit in the next cycle. So does a claim whose identity equals the source index. Bits whose mask is 0 are left unchanged.
- R5: In edge modes, a 0-to-1 change of the rectified input between two consecutive cycles sets the bit in the next cycle. A masked software write of 1 also sets it.
- R6: If a set event and a clear event reach the same source in the same cycle, the bit ends up set.
- R7: In level modes, the pending output equals the rectified input in the same cycle, with no register delay.
- R8: In level modes, software writes and claims have no effect on the pending output.
- R9: In the cycle of a configuration write to a source, no edge is detected for that source. If an edge mode is written while the rectified input is already high, the bit stays clear until the input falls and then rises again.
- R10: Writing a level mode while the rectified input is high makes the source pending immediately.
- R11: A claim affects only the source it names.
- R12: After reset, all pending bits and all stored previous rectified values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_raw | input | NSRC | Raw interrupt wires, already synchronised |
| src_mode | input | 3*NSRC | Per-source mode; source i uses bits [3i+2:3i] |
| cfg_wr_en | input | 1 | A source configuration was written this cycle |
| cfg_wr_id | input | IDW | Index of the source whose configuration was written |
| sw_wr_en | input | 1 | Software write to the pending bits |
| sw_wr_mask | input | NSRC | Bits selected by the software write |
| sw_wr_data | input | NSRC | Values written to the selected bits |
| claim_en | input | 1 | Claim strobe from a top-interrupt write |
| claim_id | input | IDW | Identity of the claimed source |
| pend | output | NSRC | Pending vector |

## Verification
The assertions check these rules every cycle, for every source:
- the inactive hold;
- detached immunity to the wire;
- set on an edge;
- set winning over clear;
- clears that take effect;
- level mirroring against the raw port;
- the rule that no pending bit appears on a configuration write in an edge mode.

Some behaviour needs a sequence of stimulus and can only be shown by the bench's scenarios:
- re-arming after a configuration write in an edge mode, which needs a fall and a fresh rise;
- the immediate set when a level mode is written;
- a claim touching only its target;
- long mixed runs of mode rewrites, masked writes and claims, checked against an independent per-cycle model.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SM_INACTIVE = 3'd0,
    SM_DETACHED = 3'd1,
    SM_RSV2     = 3'd2,
    SM_RSV3     = 3'd3,
    SM_EDGE_HI  = 3'd4,
    SM_EDGE_LO  = 3'd5,
    SM_LEVEL_HI = 3'd6,
    SM_LEVEL_LO = 3'd7
  } src_mode_e;

  function automatic logic mode_is_edge(input logic [MODE_W-1:0] m);
    return (m == SM_EDGE_HI) || (m == SM_EDGE_LO);
  endfunction

  function automatic logic mode_is_level(input logic [MODE_W-1:0] m);
    return (m == SM_LEVEL_HI) || (m == SM_LEVEL_LO);
  endfunction

  function automatic logic mode_is_detached(input logic [MODE_W-1:0] m);
    return m == SM_DETACHED;
  endfunction

  // Polarity-corrected wire; zero for modes that do not look at the wire.
  function automatic logic rectify(input logic [MODE_W-1:0] m, input logic raw);
    logic r;
    case (src_mode_e'(m))
      SM_EDGE_HI, SM_LEVEL_HI: r = raw;
      SM_EDGE_LO, SM_LEVEL_LO: r = ~raw;
      default:                 r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_id_decode.sv
module irq_id_decode #(
  parameter int NSRC = 32,
  parameter int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            en,
  input  logic [IDW-1:0]  id,
  output logic [NSRC-1:0] hit
);

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_dec
    assign hit[gi] = en && (id == IDW'(gi));
  end

endmodule

// File: rtl/irq_rect_edge.sv
module irq_rect_edge
  import irq_pend_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC*MODE_W-1:0] src_mode,
  input  logic [NSRC-1:0]        irq_raw,
  input  logic [NSRC-1:0]        cfg_hit,
  output logic [NSRC-1:0]        rect,
  output logic [NSRC-1:0]        rise
);

  logic [NSRC-1:0] prev_q;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_rect
    assign rect[gi] = rectify(src_mode[gi*MODE_W +: MODE_W], irq_raw[gi]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= rect;
  end

  // A configuration write re-bases the edge detector without firing it.
  assign rise = rect & ~prev_q & ~cfg_hit;

endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
  import irq_pend_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              rect,
  input  logic              rise,
  input  logic              sw_set,
  input  logic              sw_clr,
  input  logic              claim_hit,
  output logic              pend_o
);

  logic p_q, p_d;
  logic set_evt, clr_evt;
  logic is_edge, is_level, is_det, is_off;

  assign is_edge  = mode_is_edge(mode);
  assign is_level = mode_is_level(mode);
  assign is_det   = mode_is_detached(mode);
  assign is_off   = !is_edge && !is_level && !is_det;

  always_comb begin
    set_evt = 1'b0;
    clr_evt = 1'b0;
    if (is_edge) begin
      set_evt = rise || sw_set;
      clr_evt = sw_clr || claim_hit;
    end else if (is_det) begin
      set_evt = sw_set;
      clr_evt = sw_clr || claim_hit;
    end
  end

  always_comb begin
    if (is_level)      p_d = rect;
    else if (is_off)   p_d = 1'b0;
    else if (set_evt)  p_d = 1'b1;
    else if (clr_evt)  p_d = 1'b0;
    else               p_d = p_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) p_q <= 1'b0;
    else        p_q <= p_d;
  end

  assign pend_o = is_level ? rect : p_q;

  AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_off |=> !p_q); // R2
  AST_DETACHED_NO_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_det && !sw_set && !p_q) |=> !p_q); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !p_q); // R4
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge && rise) |=> p_q); // R5
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && clr_evt) |=> p_q); // R6

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_pend_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int IDW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        irq_raw,
  input  logic [NSRC*MODE_W-1:0] src_mode,
  input  logic                   cfg_wr_en,
  input  logic [IDW-1:0]         cfg_wr_id,
  input  logic                   sw_wr_en,
  input  logic [NSRC-1:0]        sw_wr_mask,
  input  logic [NSRC-1:0]        sw_wr_data,
  input  logic                   claim_en,
  input  logic [IDW-1:0]         claim_id,
  output logic [NSRC-1:0]        pend
);

  logic [NSRC-1:0] cfg_hit, claim_hit;
  logic [NSRC-1:0] rect, rise;
  logic [NSRC-1:0] sw_set, sw_clr;

  assign sw_set = {NSRC{sw_wr_en}} & sw_wr_mask &  sw_wr_data;
  assign sw_clr = {NSRC{sw_wr_en}} & sw_wr_mask & ~sw_wr_data;

  irq_id_decode #(.NSRC(NSRC), .IDW(IDW)) u_cfg_dec (
    .en(cfg_wr_en), .id(cfg_wr_id), .hit(cfg_hit)
  );

  irq_id_decode #(.NSRC(NSRC), .IDW(IDW)) u_claim_dec (
    .en(claim_en), .id(claim_id), .hit(claim_hit)
  );

  irq_rect_edge #(.NSRC(NSRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .src_mode(src_mode), .irq_raw(irq_raw),
    .cfg_hit(cfg_hit), .rect(rect), .rise(rise)
  );

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    logic [MODE_W-1:0] mode_i;
    assign mode_i = src_mode[gi*MODE_W +: MODE_W];

    irq_pend_cell u_cell (
      .clk(clk), .rst_n(rst_n), .mode(mode_i), .rect(rect[gi]),
      .rise(rise[gi]), .sw_set(sw_set[gi]), .sw_clr(sw_clr[gi]),
      .claim_hit(claim_hit[gi]), .pend_o(pend[gi])
    );

    AST_LEVEL_MIRRORS_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_is_level(mode_i) |-> (pend[gi] == (irq_raw[gi] ^ (mode_i == SM_LEVEL_LO)))); // R7
    AST_CFG_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_is_edge(mode_i) && cfg_wr_en && cfg_wr_id == IDW'(gi) && !pend[gi] && !sw_set[gi])
      |=> (!$stable(mode_i) || !pend[gi])); // R9
  end

endmodule

// File: tb/irq_pend_bank_tb.sv
module irq_pend_bank_tb;

  localparam int N   = 16;
  localparam int IW  = 4;
  localparam int MW  = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq_raw;
  logic [N*MW-1:0] src_mode;
  logic          cfg_wr_en;
  logic [IW-1:0] cfg_wr_id;
  logic          sw_wr_en;
  logic [N-1:0]  sw_wr_mask, sw_wr_data;
  logic          claim_en;
  logic [IW-1:0] claim_id;
  logic [N-1:0]  pend;

  int total = 0;
  int fails = 0;
  string cur_req = "R12";

  bit mp [N];
  bit mprev [N];

  always #5 clk = ~clk;

  irq_pend_bank #(.NSRC(N), .IDW(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .src_mode(src_mode),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_id(cfg_wr_id), .sw_wr_en(sw_wr_en),
    .sw_wr_mask(sw_wr_mask), .sw_wr_data(sw_wr_data), .claim_en(claim_en),
    .claim_id(claim_id), .pend(pend)
  );

  function automatic int mode_of(int i);
    return int'(src_mode[i*MW +: MW]);
  endfunction

  function automatic bit rect_m(int m, bit r);
    if (m == 4 || m == 6) return r;
    if (m == 5 || m == 7) return !r;
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] model_out();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      int m = mode_of(i);
      v[i] = (m == 6 || m == 7) ? rect_m(m, irq_raw[i]) : mp[i];
    end
    return v;
  endfunction

  task automatic model_update();
    for (int i = 0; i < N; i++) begin
      int m  = mode_of(i);
      bit r  = rect_m(m, irq_raw[i]);
      bit ws = sw_wr_en && sw_wr_mask[i] && sw_wr_data[i];
      bit wc = sw_wr_en && sw_wr_mask[i] && !sw_wr_data[i];
      bit cl = claim_en && (int'(claim_id) == i);
      bit cf = cfg_wr_en && (int'(cfg_wr_id) == i);
      bit ed = r && !mprev[i] && !cf;
      if (m == 6 || m == 7) mp[i] = r;
      else if (m == 4 || m == 5) begin
        if (ed || ws) mp[i] = 1'b1;
        else if (wc || cl) mp[i] = 1'b0;
      end else if (m == 1) begin
        if (ws) mp[i] = 1'b1;
        else if (wc || cl) mp[i] = 1'b0;
      end else mp[i] = 1'b0;
      mprev[i] = r;
    end
  endtask

  task automatic chk_vec(string req, logic [N-1:0] got, logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: pend got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chk_bit(string req, int idx, logic exp);
    total++;
    if (pend[idx] !== exp) begin
      fails++;
      $display("FAIL %s: pend[%0d] got %b expected %b", req, idx, pend[idx], exp);
    end
  endtask

  // One clock: model advances with the DUT, compare after the edge.
  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk_vec(cur_req, pend, model_out());
    cfg_wr_en = 1'b0;
    sw_wr_en  = 1'b0;
    claim_en  = 1'b0;
  endtask

  task automatic write_mode(int id, int m);
    src_mode[id*MW +: MW] = MW'(m);
    cfg_wr_en = 1'b1;
    cfg_wr_id = IW'(id);
    tick();
  endtask

  task automatic sw_write(logic [N-1:0] mask, logic [N-1:0] data);
    sw_wr_en = 1'b1; sw_wr_mask = mask; sw_wr_data = data;
  endtask

  task automatic claim(int id);
    claim_en = 1'b1; claim_id = IW'(id);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_raw = '0; src_mode = '0;
    cfg_wr_en = 0; cfg_wr_id = '0; sw_wr_en = 0; sw_wr_mask = '0; sw_wr_data = '0;
    claim_en = 0; claim_id = '0;
    for (int i = 0; i < N; i++) begin mp[i] = 0; mprev[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_vec("R12", pend, '0);
    rst_n = 1'b1;

    // R2: inactive sources ignore wires, writes and claims
    cur_req = "R2";
    irq_raw = '1; sw_write('1, '1); tick();
    chk_vec("R2", pend, '0);
    irq_raw = 16'h5a5a; claim(3); tick();
    write_mode(12, 2); write_mode(13, 3);
    irq_raw = 16'hffff; sw_write('1, '1); tick();
    chk_bit("R2", 12, 1'b0); chk_bit("R2", 13, 1'b0);

    // R9: edge mode written while rectified input is high
    cur_req = "R9";
    irq_raw = '0; irq_raw[4] = 1'b1; tick();
    write_mode(4, 4);
    chk_bit("R9", 4, 1'b0);
    tick(); chk_bit("R9", 4, 1'b0);
    irq_raw[4] = 1'b0; tick(); chk_bit("R9", 4, 1'b0);
    irq_raw[4] = 1'b1; tick(); chk_bit("R5", 4, 1'b1);

    // R6: rising edge and software clear together
    cur_req = "R6";
    write_mode(5, 4); tick();
    irq_raw[5] = 1'b1; sw_write(16'h0020, 16'h0000); tick();
    chk_bit("R6", 5, 1'b1);
    sw_write(16'h0020, 16'h0000); tick();
    chk_bit("R4", 5, 1'b0);

    // R1: falling-edge polarity
    cur_req = "R1";
    irq_raw[6] = 1'b1; write_mode(6, 5); tick();
    chk_bit("R1", 6, 1'b0);
    irq_raw[6] = 1'b0; tick();
    chk_bit("R1", 6, 1'b1);

    // R10 / R7: level mode written with input high
    cur_req = "R10";
    irq_raw[8] = 1'b1; write_mode(8, 6);
    chk_bit("R10", 8, 1'b1);
    irq_raw[8] = 1'b0;
    #1 chk_bit("R7", 8, 1'b0);
    tick();
    irq_raw[9] = 1'b0; write_mode(9, 7);
    chk_bit("R1", 9, 1'b1);

    // R8: level sources ignore writes and claims
    cur_req = "R8";
    sw_write(16'h0300, 16'h0000); claim(9); tick();
    chk_bit("R8", 9, 1'b1);
    sw_write(16'h0100, 16'h0100); tick();
    chk_bit("R8", 8, 1'b0);

    // R3 / R11: detached sources
    cur_req = "R3";
    write_mode(0, 1); write_mode(1, 1); write_mode(2, 1);
    irq_raw[2:0] = 3'b111; tick(); irq_raw[2:0] = 3'b000; tick();
    irq_raw[2:0] = 3'b111; tick();
    chk_bit("R3", 2, 1'b0);
    sw_write(16'h0003, 16'h0003); tick();
    chk_bit("R3", 0, 1'b1);
    cur_req = "R11";
    claim(0); tick();
    chk_bit("R11", 0, 1'b0); chk_bit("R11", 1, 1'b1);
    sw_write(16'h0004, 16'h0004); claim(2); tick();
    chk_bit("R6", 2, 1'b1);
    sw_write(16'h0002, 16'h0000); tick();
    chk_bit("R4", 1, 1'b0); chk_bit("R4", 2, 1'b1);

    // Mixed random run against the model (R1 R4 R5 R7 R9)
    cur_req = "R5";
    for (int c = 0; c < 2000; c++) begin
      irq_raw = N'($urandom);
      if ($urandom_range(0, 2) == 0) sw_write(N'($urandom), N'($urandom));
      if ($urandom_range(0, 3) == 0) claim($urandom_range(0, N - 1));
      if ($urandom_range(0, 7) == 0) begin
        int id = $urandom_range(0, N - 1);
        src_mode[id*MW +: MW] = MW'($urandom_range(0, 7));
        cfg_wr_en = 1'b1; cfg_wr_id = IW'(id);
      end
      tick();
    end

    summary();
    $finish;
  end

endmodule